// File: doc/BRIEF.md
# Step-Direction Phase Translator

This block turns a step-pulse train into the switching pattern of a two-winding bipolar stepper motor. It keeps a rotor index of eight positions (0 to 7). Each rising edge of the step input moves the index one sequence increment. A direction level and a half/full mode level are captured at that same edge. The index is decoded into a current direction for each winding. The enables for the high-side and low-side switches of the four motor terminals come from that decode. An active-low origin flag marks position 0.

A mode state machine arbitrates the control inputs. It has five states:

- `MODE_INIT`: the initialise input is low.
- `MODE_FAULT`: the external protection input is high.
- `MODE_IDLE`: the enable input is low.
- `MODE_BRAKE`: the brake input is high.
- `MODE_DRIVE`: normal operation.

The state is chosen in the order INIT, FAULT, IDLE, BRAKE, DRIVE. Any state can move to any other in one clock, and the choice is made again every cycle from the current levels. Two things depend on the state: whether a step edge is accepted (IDLE and DRIVE only), and what the terminals drive. All inputs are already synchronous to `clk`. The initialise input also serves as the block's synchronous reset.

Top module: `stepdir_translator`

## Requirements
- R1: Each rising edge of `step_i` (low in one clock, high in the next) moves the position by exactly one sequence increment, provided the edge is accepted. A falling edge or a held level never changes the position.
- R2: With `half_i` high, an accepted edge moves the position by +1 or -1, wrapping modulo 8 (7 to 0 forward, 0 to 7 reverse).
- R3: With `half_i` low, an accepted edge from an even position moves it by +2 or -2 modulo 8. From an odd position it moves to the adjacent even position in the commanded direction.
- R4: `dir_i` low means forward (increasing position) and high means reverse. `dir_i` and `half_i` matter only in the cycle where the rising edge is seen.
- R5: In `MODE_DRIVE`, a winding at -100 % turns on terminal A's low side and terminal B's high side. At +100 % it turns on A's high side and B's low side. At 0 % all four switches of that winding are off. Terminal bits are: bit 0 = winding 1 A, bit 1 = winding 1 B, bit 2 = winding 2 A, bit 3 = winding 2 B.
- R6: While `init_n` is low, the position is 0, every switch is off and step edges are ignored. This holds whatever the other inputs are.
- R7: While `enable_i` is low (and neither init nor fault is active), every switch is off, but step edges still advance the position. This overrides brake.
- R8: While `brake_i` is high in `MODE_BRAKE`, all four high sides are on, all low sides are off, and step edges are ignored.
- R9: A change on `init_n`, `fault_i`, `enable_i` or `brake_i` shows at the outputs after the first rising clock edge that samples it, and not before.
- R10: `origin_n_o` is low exactly when the position is 0.
- R11: While `fault_i` is high (and init is not active), every switch is off, the position is held and step edges are ignored. Fault ranks below init and above enable.
- R12: `wind_cur_o` gives the current direction of winding w in bits [2w+1:2w], in every mode. The codes are 2'b11 = -100 %, 2'b00 = 0 %, 2'b01 = +100 %. Winding 1 by position 0..7 is -,0,+,+,+,0,-,-. Winding 2 is -,-,-,0,+,+,+,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_n | input | 1 | Active-low initialise; also the synchronous reset |
| step_i | input | 1 | Step pulse; rising edge advances |
| dir_i | input | 1 | Direction, low = forward |
| half_i | input | 1 | Step size, high = half step |
| enable_i | input | 1 | Output enable, high = outputs may drive |
| brake_i | input | 1 | Short brake request |
| fault_i | input | 1 | Protection outputs-off request |
| hs_en_o | output | 4 | High-side switch enable per terminal |
| ls_en_o | output | 4 | Low-side switch enable per terminal |
| wind_cur_o | output | 4 | Signed current-direction code per winding |
| origin_n_o | output | 1 | Low at position 0 |

## Verification
The sequence is tried in several ways:

- A full-step forward run that wraps around 0. This shows the +2 increment and the origin flag.
- Half-step runs in both directions across both wrap points. These separate the ±1 increment from the ±2 one and show the zero-current positions.
- Switches into full-step mode from an odd position, in each direction. These expose any rounding that goes the wrong way.

Each control level is then held during a step pulse. A pulse under enable-low must advance the position. Pulses under brake, fault and initialise must not. These cases tell the step-acceptance rule apart from the output-blanking rule. Overlaps (enable with brake, initialise with brake) confirm the priority order. Outputs are also sampled just before and just after the clock edge that follows a control change, to pin down the one-cycle response.

// File: rtl/stepdir_pkg.sv
package stepdir_pkg;

    localparam int POS_W   = 3;
    localparam int NUM_POS = 1 << POS_W;
    localparam int QUARTER = NUM_POS / 4;

    typedef enum logic [2:0] {
        MODE_INIT,
        MODE_FAULT,
        MODE_IDLE,
        MODE_BRAKE,
        MODE_DRIVE
    } drv_mode_e;

    typedef enum logic [1:0] {
        CUR_ZERO = 2'b00,
        CUR_POS  = 2'b01,
        CUR_NEG  = 2'b11
    } cur_dir_e;

    // Current direction of a winding whose own phase is ph (winding 1 reference).
    function automatic cur_dir_e cur_of_phase(input logic [POS_W-1:0] ph);
        cur_dir_e c;
        unique case (ph)
            3'd1, 3'd5:       c = CUR_ZERO;
            3'd2, 3'd3, 3'd4: c = CUR_POS;
            default:          c = CUR_NEG;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sdt_step_edge.sv
module sdt_step_edge (
    input  logic clk,
    input  logic init_n,
    input  logic step_i,
    output logic rise_o,
    output logic fall_o
);

    logic step_q;

    always_ff @(posedge clk) begin
        step_q <= step_i;
    end

    assign rise_o = step_i & ~step_q;
    assign fall_o = ~step_i & step_q;

    // R1: a rising edge needs a low sample first, so two in a row are impossible
    p_no_double_rise_r1: assert property (@(posedge clk) disable iff (!init_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sdt_seq_ctrl.sv
module sdt_seq_ctrl
    import stepdir_pkg::*;
(
    input  logic             clk,
    input  logic             init_n,
    input  logic             enable_i,
    input  logic             brake_i,
    input  logic             fault_i,
    input  logic             dir_i,
    input  logic             half_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output drv_mode_e        mode_o,
    output logic [POS_W-1:0] pos_o
);

    drv_mode_e        mode_q, mode_nxt;
    logic [POS_W-1:0] pos_q, pos_nxt;
    logic             accept;

    // Mode selection: init > fault > enable > brake > drive
    always_comb begin
        if (!init_n)        mode_nxt = MODE_INIT;
        else if (fault_i)   mode_nxt = MODE_FAULT;
        else if (!enable_i) mode_nxt = MODE_IDLE;
        else if (brake_i)   mode_nxt = MODE_BRAKE;
        else                mode_nxt = MODE_DRIVE;
    end

    always_comb begin
        unique case (mode_nxt)
            MODE_IDLE, MODE_DRIVE: accept = 1'b1;
            default:               accept = 1'b0;
        endcase
    end

    // Next index: half step +-1, full step +-2 from even, +-1 from odd
    always_comb begin
        unique case ({half_i, dir_i})
            2'b10:   pos_nxt = pos_q + POS_W'(1);
            2'b11:   pos_nxt = pos_q - POS_W'(1);
            2'b00:   pos_nxt = pos_q[0] ? pos_q + POS_W'(1) : pos_q + POS_W'(2);
            default: pos_nxt = pos_q[0] ? pos_q - POS_W'(1) : pos_q - POS_W'(2);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!init_n) begin
            mode_q <= MODE_INIT;
            pos_q  <= '0;
        end else begin
            mode_q <= mode_nxt;
            if (rise_i && accept) begin
                pos_q <= pos_nxt;
            end
        end
    end

    assign mode_o = mode_q;
    assign pos_o  = pos_q;

    // R1: a falling edge leaves the index alone
    p_fall_hold_r1: assert property (@(posedge clk) disable iff (!init_n)
        fall_i |=> $stable(pos_q));

    // R2: an accepted half step always moves the index
    p_half_moves_r2: assert property (@(posedge clk) disable iff (!init_n)
        (rise_i && half_i && !fault_i && (!enable_i || !brake_i)) |=> !$stable(pos_q));

    // R3: an accepted full step always lands on an even index
    p_full_even_r3: assert property (@(posedge clk) disable iff (!init_n)
        (rise_i && !half_i && !fault_i && (!enable_i || !brake_i)) |=> !pos_q[0]);

    // R8: braking freezes the sequence
    p_brake_freeze_r8: assert property (@(posedge clk) disable iff (!init_n)
        (brake_i && enable_i) |=> $stable(pos_q));

    // R11: fault freezes the sequence
    p_fault_freeze_r11: assert property (@(posedge clk) disable iff (!init_n)
        fault_i |=> $stable(pos_q));

endmodule

// File: rtl/sdt_phase_map.sv
module sdt_phase_map
    import stepdir_pkg::*;
#(
    parameter int NUM_WIND = 2,
    localparam int NUM_TERM = 2 * NUM_WIND
) (
    input  drv_mode_e             mode_i,
    input  logic [POS_W-1:0]      pos_i,
    output logic [NUM_TERM-1:0]   hs_en_o,
    output logic [NUM_TERM-1:0]   ls_en_o,
    output logic [NUM_TERM-1:0]   cur_o,
    output logic                  origin_n_o
);

    for (genvar w = 0; w < NUM_WIND; w++) begin : g_wind
        localparam logic [POS_W-1:0] OFS = POS_W'(w * QUARTER);
        logic [POS_W-1:0] ph;
        cur_dir_e         cur;

        assign ph  = pos_i - OFS;
        assign cur = cur_of_phase(ph);
        assign cur_o[2*w +: 2] = cur;

        always_comb begin
            unique case (mode_i)
                MODE_DRIVE: begin
                    hs_en_o[2*w]   = (cur == CUR_POS);
                    ls_en_o[2*w]   = (cur == CUR_NEG);
                    hs_en_o[2*w+1] = (cur == CUR_NEG);
                    ls_en_o[2*w+1] = (cur == CUR_POS);
                end
                MODE_BRAKE: begin
                    hs_en_o[2*w +: 2] = 2'b11;
                    ls_en_o[2*w +: 2] = 2'b00;
                end
                default: begin
                    hs_en_o[2*w +: 2] = 2'b00;
                    ls_en_o[2*w +: 2] = 2'b00;
                end
            endcase
        end
    end

    assign origin_n_o = |pos_i;

endmodule

// File: rtl/stepdir_translator.sv
module stepdir_translator
    import stepdir_pkg::*;
#(
    parameter int NUM_WIND = 2,
    localparam int NUM_TERM = 2 * NUM_WIND
) (
    input  logic                clk,
    input  logic                init_n,
    input  logic                step_i,
    input  logic                dir_i,
    input  logic                half_i,
    input  logic                enable_i,
    input  logic                brake_i,
    input  logic                fault_i,
    output logic [NUM_TERM-1:0] hs_en_o,
    output logic [NUM_TERM-1:0] ls_en_o,
    output logic [NUM_TERM-1:0] wind_cur_o,
    output logic                origin_n_o
);

    logic             rise, fall;
    drv_mode_e        mode;
    logic [POS_W-1:0] pos;

    sdt_step_edge u_edge (
        .clk    (clk),
        .init_n (init_n),
        .step_i (step_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    sdt_seq_ctrl u_ctrl (
        .clk      (clk),
        .init_n   (init_n),
        .enable_i (enable_i),
        .brake_i  (brake_i),
        .fault_i  (fault_i),
        .dir_i    (dir_i),
        .half_i   (half_i),
        .rise_i   (rise),
        .fall_i   (fall),
        .mode_o   (mode),
        .pos_o    (pos)
    );

    sdt_phase_map #(.NUM_WIND(NUM_WIND)) u_map (
        .mode_i     (mode),
        .pos_i      (pos),
        .hs_en_o    (hs_en_o),
        .ls_en_o    (ls_en_o),
        .cur_o      (wind_cur_o),
        .origin_n_o (origin_n_o)
    );

    // R5: no terminal ever has both switches on
    p_no_shoot_r5: assert property (@(posedge clk) disable iff (!init_n)
        (hs_en_o & ls_en_o) == '0);

    // R7: enable low blanks all switches on the next cycle
    p_idle_off_r7: assert property (@(posedge clk) disable iff (!init_n)
        (!enable_i && !fault_i) |=> (hs_en_o == '0 && ls_en_o == '0));

    // R8: brake with enable high gives all high sides, no low sides
    p_brake_out_r8: assert property (@(posedge clk) disable iff (!init_n)
        (brake_i && enable_i && !fault_i) |=> (ls_en_o == '0 && hs_en_o == '1));

    // R11: fault blanks all switches on the next cycle
    p_fault_off_r11: assert property (@(posedge clk) disable iff (!init_n)
        fault_i |=> (hs_en_o == '0 && ls_en_o == '0));

endmodule

// File: tb/stepdir_translator_bench.sv
module stepdir_translator_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          init_n, step, dir, half, en, brk, flt;
    logic [NT-1:0] hs, ls, cur;
    logic          mo_n;
    int            tests = 0;
    int            fails = 0;

    stepdir_translator u_stepdir_translator (
        .clk(clk), .init_n(init_n), .step_i(step), .dir_i(dir), .half_i(half),
        .enable_i(en), .brake_i(brk), .fault_i(flt),
        .hs_en_o(hs), .ls_en_o(ls), .wind_cur_o(cur), .origin_n_o(mo_n)
    );

    // mode: 0 drive, 1 all off, 2 brake
    typedef struct packed {
        logic       st;
        logic       dir;
        logic       hsm;
        logic       en;
        logic       brk;
        logic       flt;
        logic [2:0] pos;
        logic [1:0] mode;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,2'd0,4'd3},  // R3 full fwd
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,2'd0,4'd3},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd6,2'd0,4'd3},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,2'd0,4'd10}, // R10 wrap to origin
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd1,2'd0,4'd2},  // R2 half fwd
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd2,2'd0,4'd2},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd3,2'd0,4'd2},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,3'd4,2'd0,4'd3},  // R3 odd -> even fwd
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,3'd5,2'd0,4'd5},  // R5 zero winding
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,3'd4,2'd0,4'd4},  // R4 odd -> even rev
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,3'd2,2'd0,4'd4},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd1,2'd0,4'd2},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd0,2'd0,4'd2},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd7,2'd0,4'd2},  // R2 reverse wrap
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,3'd6,2'd0,4'd3},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,2'd1,4'd7},  // R7 steps while off
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,2'd1,4'd7},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,3'd0,2'd2,4'd8},  // R8 brake ignores step
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'd2,2'd1,4'd7},  // R7 enable beats brake
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,3'd2,2'd1,4'd11}, // R11 fault
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,2'd0,4'd11},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd1,2'd0,4'd12}  // R12 code follows
    };

    // R12 winding 1 table; winding 2 is the same shifted by two positions
    function automatic logic [1:0] exp_cur(input int w, input logic [2:0] pos);
        logic [2:0] ph;
        ph = pos - 3'(2 * w);
        case (ph)
            3'd1, 3'd5:       return 2'b00;
            3'd2, 3'd3, 3'd4: return 2'b01;
            default:          return 2'b11;
        endcase
    endfunction

    task automatic check(input int req, input logic [2:0] pos, input logic [1:0] mode);
        logic [NT-1:0] ehs, els, ecur;
        logic          emo;
        for (int w = 0; w < NT / 2; w++) begin
            logic [1:0] c;
            c = exp_cur(w, pos);
            ecur[2*w +: 2] = c;
            if (mode == 2'd0) begin
                ehs[2*w]   = (c == 2'b01);
                els[2*w]   = (c == 2'b11);
                ehs[2*w+1] = (c == 2'b11);
                els[2*w+1] = (c == 2'b01);
            end else if (mode == 2'd2) begin
                ehs[2*w +: 2] = 2'b11;
                els[2*w +: 2] = 2'b00;
            end else begin
                ehs[2*w +: 2] = 2'b00;
                els[2*w +: 2] = 2'b00;
            end
        end
        emo = (pos != 3'd0);
        tests++;
        if (hs !== ehs || ls !== els || cur !== ecur || mo_n !== emo) begin
            fails++;
            $display("FAIL R%0d: hs=%b ls=%b cur=%b mo_n=%b expected hs=%b ls=%b cur=%b mo_n=%b",
                     req, hs, ls, cur, mo_n, ehs, els, ecur, emo);
        end
    endtask

    task automatic apply(input logic s, input logic d, input logic h,
                         input logic e, input logic b, input logic f);
        @(negedge clk);
        dir = d; half = h; en = e; brk = b; flt = f; step = s;
        @(negedge clk);
        step = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        init_n = 1'b0; step = 1'b0; dir = 1'b0; half = 1'b0;
        en = 1'b1; brk = 1'b0; flt = 1'b0;
        repeat (3) @(negedge clk);
        check(6, 3'd0, 2'd1);                   // R6 reset state
        init_n = 1'b1;
        @(negedge clk);
        check(5, 3'd0, 2'd0);                   // R5 drive at origin

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].st, VEC[i].dir, VEC[i].hsm, VEC[i].en, VEC[i].brk, VEC[i].flt);
            check(int'(VEC[i].req), VEC[i].pos, VEC[i].mode);
        end

        // R1: rise advances, holding high and falling do not
        @(negedge clk);
        dir = 1'b0; half = 1'b1; step = 1'b1;
        @(negedge clk);
        check(1, 3'd2, 2'd0);
        dir = 1'b1;                             // R4: change after the edge is ignored
        repeat (2) @(negedge clk);
        check(4, 3'd2, 2'd0);
        step = 1'b0;
        repeat (2) @(negedge clk);
        check(1, 3'd2, 2'd0);

        // R6: init beats brake and blocks steps, then returns to origin
        init_n = 1'b0; brk = 1'b1;
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        check(6, 3'd0, 2'd1);
        @(negedge clk);
        init_n = 1'b1; en = 1'b1; flt = 1'b0;
        @(negedge clk);
        check(8, 3'd0, 2'd2);                   // R8 brake outputs
        brk = 1'b0;
        @(negedge clk);
        check(5, 3'd0, 2'd0);

        // R9: control change visible only after the next clock edge
        @(negedge clk);
        en = 1'b0;
        #1;
        check(9, 3'd0, 2'd0);
        @(negedge clk);
        check(9, 3'd0, 2'd1);
        en = 1'b1;
        @(negedge clk);
        check(9, 3'd0, 2'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule